// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps a 64-bit free-running count that advances at a fixed nominal rate, even though it is clocked from a faster system clock whose frequency differs from board to board. On every system clock a fractional step of num/den is added to a phase accumulator. Each time the accumulator reaches den, den is taken back out, the count moves up by exactly one, and a one-cycle tick is raised. The long-run count rate is therefore the clock rate times num/den. For example, a 38.4 MHz clock with 4/25 gives 6.144 MHz, and so do 19.2 MHz with 8/25, 12 MHz with 64/125, 20 MHz with 192/625 and 26 MHz with 384/1625. The ratio 75/244 is the setting used when the slow reference comes from the system clock instead of a crystal.

Software reaches the block through a plain register port with a write strobe and a read strobe. Read data appears one cycle after the read strobe. There is no back-pressure: every access completes in the cycle it is presented. Two 32-bit ratio registers hold num and den in their low 12 bits. The 64-bit count is read as two halves, and reading the low half freezes a copy of the high half so that the pair read back is consistent. The count is also available in parallel on an output port.

Top module: `rtc_frac_counter`

## Requirements
- R1: Synchronous active-high reset sets the count to 0, sets tick low, clears the accumulator and loads the numerator register with 0x00000004 and the denominator register with 0x00000019 (4/25).
- R2: With a valid ratio, k clocks after a clean phase the count equals its starting value plus floor(k*num/den).
- R3: The tick output is high in exactly the cycles in which the count has just advanced by one. In every other cycle the count holds its value.
- R4: With num equal to den (and den non-zero), the count advances on every clock.
- R5: A write to the numerator register (byte offset 0x10) or the denominator register (byte offset 0x14) clears the accumulator. That clock does not advance the count, and R2 then holds counting from the write.
- R6: Only bits [11:0] of each ratio register set num or den. Bits [31:12] are stored and read back as written, and have no effect on counting.
- R7: While den is 0 or num is greater than den, the count holds its value and tick stays low. Counting resumes once a valid ratio is written.
- R8: A read of byte offset 0x00 returns count[31:0] as sampled at the read clock and captures count[63:32]. A read of offset 0x04 returns the captured upper half. Read data is valid on the cycle after the read strobe.
- R9: Writes to offsets 0x00, 0x04 and any unmapped offset have no effect on the count or the ratio registers. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd_en |
| count_o | output | 64 | Current count value |
| tick_o | output | 1 | One-cycle pulse in the cycle the count has advanced |

## Verification
The bench compares the count cycle by cycle against floor(k*num/den) for several clock/ratio pairs, including the 75/244 setting and a 3/7 ratio whose remainder pattern is irregular. A design that subtracted den late, or compared with > instead of >=, would drift by one step within the first period. Writes are placed mid-phase to catch an accumulator that keeps a stale remainder, which would show up as an early tick after the write. Invalid ratios (den of 0, and num above den) are held for many cycles to catch a counter that wraps or divides by zero. Writes to the upper 20 bits of each ratio register, and stray writes to the count and unmapped offsets, are checked both for readback and for no disturbance of the counting phase. A counter that ignored the full-rate case num equal to den would miss ticks in a run of consecutive steps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Byte offsets of the register window.
  localparam int unsigned OFF_CNT_LO = 32'h00;
  localparam int unsigned OFF_CNT_HI = 32'h04;
  localparam int unsigned OFF_NUM    = 32'h10;
  localparam int unsigned OFF_DEN    = 32'h14;

  // Read source selection.
  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_LO,
    RSEL_HI,
    RSEL_NUM,
    RSEL_DEN
  } rsel_e;
endpackage

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int FRAC_W  = 12,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 64,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  count,
  output logic [REG_W-1:0]  rd_data,
  output logic [FRAC_W-1:0] num,
  output logic [FRAC_W-1:0] den,
  output logic              ratio_wr
);
  localparam int HI_W     = CNT_W - REG_W;
  localparam int N_RATIO  = 2;

  logic [N_RATIO-1:0]            ratio_hit;
  logic [N_RATIO-1:0][REG_W-1:0] ratio_v;
  logic [HI_W-1:0]               hi_snap;
  logic [REG_W-1:0]              rd_next;
  rsel_e                         rsel;

  assign ratio_hit[0] = wr_en && (addr == ADDR_W'(OFF_NUM));
  assign ratio_hit[1] = wr_en && (addr == ADDR_W'(OFF_DEN));
  assign ratio_wr     = |ratio_hit;

  // One storage element per ratio register; index 0 is num, 1 is den.
  generate
    for (genvar i = 0; i < N_RATIO; i++) begin : g_ratio
      localparam logic [REG_W-1:0] RST_V = (i == 0) ? REG_W'(RST_NUM) : REG_W'(RST_DEN);
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)               q <= RST_V;
        else if (ratio_hit[i]) q <= wr_data;
      end
      assign ratio_v[i] = q;
    end
  endgenerate

  assign num = ratio_v[0][FRAC_W-1:0];
  assign den = ratio_v[1][FRAC_W-1:0];

  always_comb begin
    if      (addr == ADDR_W'(OFF_CNT_LO)) rsel = RSEL_LO;
    else if (addr == ADDR_W'(OFF_CNT_HI)) rsel = RSEL_HI;
    else if (addr == ADDR_W'(OFF_NUM))    rsel = RSEL_NUM;
    else if (addr == ADDR_W'(OFF_DEN))    rsel = RSEL_DEN;
    else                                  rsel = RSEL_NONE;
  end

  always_comb begin
    case (rsel)
      RSEL_LO:  rd_next = count[REG_W-1:0];
      RSEL_HI:  rd_next = REG_W'(hi_snap);
      RSEL_NUM: rd_next = ratio_v[0];
      RSEL_DEN: rd_next = ratio_v[1];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hi_snap <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
      if (rsel == RSEL_LO) hi_snap <= count[CNT_W-1:REG_W];
    end
  end
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  input  logic              clear,
  output logic              step,
  output logic              ratio_ok
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  den_x;
  logic [SUM_W-1:0]  wrapped;

  assign ratio_ok = (den != '0) && (num <= den);
  assign sum      = {1'b0, acc} + {1'b0, num};
  assign den_x    = {1'b0, den};
  assign wrapped  = sum - den_x;
  assign step     = ratio_ok && !clear && (sum >= den_x);

  always_ff @(posedge clk) begin
    if (rst || clear)   acc <= '0;
    else if (!ratio_ok) acc <= acc;
    else if (step)      acc <= wrapped[FRAC_W-1:0];
    else                acc <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= step;
      if (step) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int REG_W   = 32,
  parameter int FRAC_W  = 12,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 64,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              tick_o
);
  logic [FRAC_W-1:0] num_w;
  logic [FRAC_W-1:0] den_w;
  logic              ratio_wr;
  logic              step;
  logic              ratio_ok;

  rtc_regbank #(
    .REG_W(REG_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wr_data(reg_wdata), .count(count_o),
    .rd_data(reg_rdata), .num(num_w), .den(den_w), .ratio_wr(ratio_wr)
  );

  rtc_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .num(num_w), .den(den_w), .clear(ratio_wr),
    .step(step), .ratio_ok(ratio_ok)
  );

  rtc_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .step(step), .count(count_o), .tick(tick_o)
  );
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk
  import rtc_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int FRAC_W = 12,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  count_o,
  input logic              tick_o,
  input logic [FRAC_W-1:0] num_w,
  input logic [FRAC_W-1:0] den_w,
  input logic              ratio_wr
);
  logic unmapped;
  assign unmapped = (addr != ADDR_W'(OFF_CNT_LO)) && (addr != ADDR_W'(OFF_CNT_HI)) &&
                    (addr != ADDR_W'(OFF_NUM))    && (addr != ADDR_W'(OFF_DEN));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == '0) && !tick_o);

  p_tick_adv_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (count_o == $past(count_o) + 1'b1));

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick_o |-> $stable(count_o));

  p_full_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (num_w == den_w) && (den_w != '0) && !ratio_wr |=> tick_o);

  p_wr_no_step_r5: assert property (@(posedge clk) disable iff (rst)
    ratio_wr |=> !tick_o);

  p_invalid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (den_w == '0) || (num_w > den_w) |=> !tick_o);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && unmapped |=> (rd_data == '0));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(
  .REG_W(REG_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(reg_rd_en), .addr(reg_addr), .rd_data(reg_rdata),
  .count_o(count_o), .tick_o(tick_o), .num_w(num_w), .den_w(den_w), .ratio_wr(ratio_wr)
);

// File: tb/tb_rtc_frac_counter.sv
module tb_rtc_frac_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] count_o;
  logic        tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  rtc_frac_counter dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count_o(count_o), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ratio(input int n, input int d);
    wr(8'h10, 32'(n));
    wr(8'h14, 32'(d));
  endtask

  // Count must follow base + floor(k*num/den) for k = kstart+1 .. kstart+ncyc.
  task automatic run_phase(input int n, input int d, input int ncyc,
                           input longint base, input int kstart, input string req);
    for (int k = kstart + 1; k <= kstart + ncyc; k++) begin
      longint e_now, e_prev;
      @(negedge clk);
      e_now  = base + (longint'(k) * n) / d;
      e_prev = base + (longint'(k - 1) * n) / d;
      check(count_o == 64'(e_now), req, longint'(count_o), e_now);
      check(tick_o == (e_now != e_prev), {req, "/R3 tick"}, longint'(tick_o),
            longint'(e_now != e_prev));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    do_reset();
    check(count_o == 64'd0, "R1 count", longint'(count_o), 0);
    check(tick_o == 1'b0, "R1 tick", longint'(tick_o), 0);
    run_phase(4, 25, 500, 0, 0, "R1/R2 default ratio");
    do_reset();
    rd(8'h10, v); check(v == 32'h4,  "R1 num reg", longint'(v), 4);
    rd(8'h14, v); check(v == 32'h19, "R1 den reg", longint'(v), 25);
  endtask

  task automatic t_ratio_r2(input int n, input int d, input int ncyc);
    longint c0;
    set_ratio(n, d);
    c0 = longint'(count_o);
    run_phase(n, d, ncyc, c0, 0, "R2 ratio");
  endtask

  task automatic t_full_rate_r4();
    longint c0;
    set_ratio(9, 9);
    c0 = longint'(count_o);
    run_phase(9, 9, 64, c0, 0, "R4 full rate");
  endtask

  task automatic t_midphase_r5();
    longint c0;
    set_ratio(3, 7);
    run_phase(3, 7, 5, longint'(count_o), 0, "R5 pre");
    wr(8'h10, 32'd3);
    check(tick_o == 1'b0, "R5 write cycle", longint'(tick_o), 0);
    c0 = longint'(count_o);
    run_phase(3, 7, 70, c0, 0, "R5 clean phase");
    wr(8'h14, 32'd7);
    c0 = longint'(count_o);
    run_phase(3, 7, 70, c0, 0, "R5 den write");
  endtask

  task automatic t_upper_bits_r6();
    logic [31:0] v;
    longint c0;
    wr(8'h10, 32'hABCDE004);
    wr(8'h14, 32'h12345019);
    c0 = longint'(count_o);
    run_phase(4, 25, 300, c0, 0, "R6 upper bits ignored");
    rd(8'h10, v); check(v == 32'hABCDE004, "R6 num readback", longint'(v), 64'hABCDE004);
    rd(8'h14, v); check(v == 32'h12345019, "R6 den readback", longint'(v), 64'h12345019);
  endtask

  task automatic t_invalid_r7();
    longint c0;
    set_ratio(4, 25);
    run_phase(4, 25, 40, longint'(count_o), 0, "R7 pre");
    wr(8'h14, 32'd0);
    c0 = longint'(count_o);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(count_o == 64'(c0), "R7 den zero hold", longint'(count_o), c0);
      check(tick_o == 1'b0, "R7 den zero tick", longint'(tick_o), 0);
    end
    wr(8'h10, 32'd30);
    wr(8'h14, 32'd25);
    check(count_o == 64'(c0), "R7 transition hold", longint'(count_o), c0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(count_o == 64'(c0), "R7 num above den hold", longint'(count_o), c0);
      check(tick_o == 1'b0, "R7 num above den tick", longint'(tick_o), 0);
    end
    wr(8'h10, 32'd4);
    c0 = longint'(count_o);
    run_phase(4, 25, 200, c0, 0, "R7 resume");
  endtask

  task automatic t_split_read_r8();
    logic [31:0] v;
    logic [63:0] exp;
    set_ratio(4, 25);
    run_phase(4, 25, 37, longint'(count_o), 0, "R8 pre");
    exp = count_o;
    rd(8'h00, v);
    check(v == exp[31:0], "R8 low half", longint'(v), longint'(exp[31:0]));
    rd(8'h04, v);
    check(v == exp[63:32], "R8 high half", longint'(v), longint'(exp[63:32]));
  endtask

  task automatic t_ignored_r9();
    logic [31:0] v;
    longint c0;
    set_ratio(4, 25);
    c0 = longint'(count_o);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h08, 32'h00000123);
    run_phase(4, 25, 200, c0, 3, "R9 count unaffected");
    rd(8'h10, v); check(v == 32'd4,  "R9 num intact", longint'(v), 4);
    rd(8'h14, v); check(v == 32'd25, "R9 den intact", longint'(v), 25);
    rd(8'h08, v); check(v == 32'd0,  "R9 unmapped read", longint'(v), 0);
    rd(8'h3C, v); check(v == 32'd0,  "R9 unmapped read", longint'(v), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_ratio_r2(8, 25, 500);
    t_ratio_r2(64, 125, 500);
    t_ratio_r2(192, 625, 1300);
    t_ratio_r2(384, 1625, 1700);
    t_ratio_r2(75, 244, 1000);
    t_ratio_r2(3, 7, 300);
    t_full_rate_r4();
    t_midphase_r5();
    t_upper_bits_r6();
    t_invalid_r7();
    t_split_read_r8();
    t_ignored_r9();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule